// File: doc/BRIEF.md
# EDID Segment and Offset Replay Sequencer

This block sits between the request source of a display auxiliary channel and the request framer that serialises traffic onto the wire. Some display sinks lose their EDID read pointer when a read is continued with the middle-of-transaction flag set. To stop that from corrupting EDID reads, the block watches every I2C-over-AUX write aimed at the segment pointer (I2C address 0x30) or at the EDID data address (I2C address 0x50). It keeps its own copy of the current segment and the current byte offset.

Each accepted upstream request becomes a short run of framer requests. When a continued I2C read arrives in the middle of a 128-byte EDID block, the block first re-sends the segment, but only if that segment is nonzero. It then re-sends the offset. After that it forwards the read itself. Each replay moves the offset on by one 16-byte chunk. The segment falls back to zero when the offset reaches either block boundary. Frames go to the framer one at a time. Each frame waits for the framer's done or error strobe before the next is sent. A framer error stops the run and is passed upward.

Top module: `edid_replay_seq`

## Requirements
- R1: An I2C (in_native=0) write (in_read=0) to address 0x30 stores in_data0 as the segment. An I2C write to 0x50 stores in_data0 as the offset. Native requests, reads and other addresses leave both values unchanged.
- R2: A replay is performed only when all of these hold: the request is I2C, it is a read, in_mot=1, in_size is nonzero, in_send_seg=1, and the low 7 bits of the tracked offset are nonzero. Any other request produces exactly one framer request, the forwarded one.
- R3: In a replay with a nonzero segment, the first framer request is a write to address 0x30 with out_size=1 and out_data0 equal to the segment. When the segment is zero, this frame is left out.
- R4: In a replay, the offset frame is a write to the read's own address with out_size=1 and out_data0 equal to the low 8 bits of the offset. It comes directly before the forwarded read.
- R5: Both replay frames (segment and offset) carry out_no_addr=1 and out_no_stop=1, out_native=0 and out_read=0.
- R6: The forwarded frame repeats the request's native, read, address, size and data0 fields. For I2C it has out_no_addr=1 and out_no_stop equal to in_mot. For native it has both flags at 0.
- R7: Each completed offset frame advances the tracked offset by 16.
- R8: When an advance makes the offset equal to 0x80 or 0x100, the segment is cleared to 0.
- R9: out_valid is a one-cycle pulse. No further frame is issued until fr_done is seen for the previous frame.
- R10: If fr_err is seen for any frame, seq_err pulses for one cycle, no further frame of that request is issued, and a replay cut short this way does not advance the offset.
- R11: A request is taken only when in_valid=1 and in_busy=0. in_busy stays high until seq_done or seq_err pulses, and in_valid during busy is ignored. seq_done pulses once the forwarded frame is done.
- R12: Reset clears the segment and offset to 0 and returns the block to idle with out_valid, in_busy, seq_done and seq_err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream request strobe |
| in_native | input | 1 | 1 = native AUX request, 0 = I2C-over-AUX |
| in_read | input | 1 | 1 = read, 0 = write |
| in_mot | input | 1 | Middle-of-transaction flag |
| in_send_seg | input | 1 | Block-start hint; 0 suppresses replay |
| in_addr | input | ADDR_W | Request address (I2C address or native address) |
| in_size | input | SIZE_W | Request byte count |
| in_data0 | input | 8 | First data byte of the request |
| in_busy | output | 1 | Request in progress |
| out_valid | output | 1 | Framer request strobe |
| out_native | output | 1 | Framer request is native |
| out_read | output | 1 | Framer request is a read |
| out_addr | output | ADDR_W | Framer request address |
| out_size | output | SIZE_W | Framer request byte count |
| out_data0 | output | 8 | Framer request first data byte |
| out_no_addr | output | 1 | Suppress address phase |
| out_no_stop | output | 1 | Suppress stop |
| fr_done | input | 1 | Framer finished the current frame |
| fr_err | input | 1 | Framer reports failure of the current frame |
| seq_done | output | 1 | Request completed |
| seq_err | output | 1 | Request aborted on a framer error |

## Verification
Some rules are checked by the assertions on every cycle. These are the one-cycle shape of out_valid, the flag rules for native and I2C frames, that done and error never pulse together, the busy window around each accepted request, and the reset state. The segment and offset values cannot be seen from outside, so the bench scenarios have to show them. The bench drives snooped writes, continued reads with and without the hint, and offsets sitting on the 0x80 and 0x100 boundaries. It then checks the data bytes of the replay frames that follow. Abort without advance, and ignored requests while busy, are also shown only through later replay frames.

// File: rtl/edid_rs_pkg.sv
package edid_rs_pkg;

  localparam logic [7:0] SEG_PTR_ADDR  = 8'h30;
  localparam logic [7:0] EDID_DAT_ADDR = 8'h50;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SEG_SEND = 3'd1,
    ST_SEG_WAIT = 3'd2,
    ST_OFS_SEND = 3'd3,
    ST_OFS_WAIT = 3'd4,
    ST_FWD_SEND = 3'd5,
    ST_FWD_WAIT = 3'd6
  } seq_state_t;

endpackage

// File: rtl/edid_rs_tracker.sv
module edid_rs_tracker
  import edid_rs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 9,
  parameter int CHUNK  = 16,
  parameter int BLOCK  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic              cap_native,
  input  logic              cap_read,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [7:0]        cap_data,
  input  logic              adv_en,
  output logic [7:0]        seg,
  output logic [OFS_W-1:0]  ofs
);

  localparam logic [OFS_W-1:0] STEP    = OFS_W'(CHUNK);
  localparam logic [OFS_W-1:0] EDGE_LO = OFS_W'(BLOCK);
  localparam logic [OFS_W-1:0] EDGE_HI = OFS_W'(2 * BLOCK);

  logic             is_i2c_wr;
  logic             hit_seg;
  logic             hit_dat;
  logic [OFS_W-1:0] ofs_step;
  logic             at_edge;

  assign is_i2c_wr = cap_en && !cap_native && !cap_read;
  assign hit_seg   = is_i2c_wr && (cap_addr == ADDR_W'(SEG_PTR_ADDR));
  assign hit_dat   = is_i2c_wr && (cap_addr == ADDR_W'(EDID_DAT_ADDR));
  assign ofs_step  = ofs + STEP;
  assign at_edge   = (ofs_step == EDGE_LO) || (ofs_step == EDGE_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      seg <= '0;
      ofs <= '0;
    end else if (adv_en) begin
      ofs <= ofs_step;
      if (at_edge) begin
        seg <= '0;
      end
    end else begin
      if (hit_seg) begin
        seg <= cap_data;
      end
      if (hit_dat) begin
        ofs <= OFS_W'(cap_data);
      end
    end
  end

endmodule

// File: rtl/edid_rs_gate.sv
module edid_rs_gate #(
  parameter int SIZE_W = 8,
  parameter int OFS_W  = 9,
  parameter int BLOCK  = 128
) (
  input  logic              req_native,
  input  logic              req_read,
  input  logic              req_mot,
  input  logic              req_send_seg,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [7:0]        seg,
  input  logic [OFS_W-1:0]  ofs,
  output logic              do_replay,
  output logic              do_seg
);

  localparam int BLK_LG = $clog2(BLOCK);

  logic eligible;
  logic mid_block;

  assign eligible  = !req_native && req_read && req_mot && (req_size != '0);
  assign mid_block = (ofs[BLK_LG-1:0] != '0);
  assign do_replay = eligible && req_send_seg && mid_block;
  assign do_seg    = do_replay && (seg != 8'h00);

endmodule

// File: rtl/edid_rs_ctrl.sv
module edid_rs_ctrl
  import edid_rs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int SIZE_W = 8,
  parameter int OFS_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_native,
  input  logic              in_read,
  input  logic              in_mot,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [SIZE_W-1:0] in_size,
  input  logic [7:0]        in_data0,
  input  logic              do_replay,
  input  logic              do_seg,
  input  logic [7:0]        seg,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              fr_done,
  input  logic              fr_err,
  output logic              accept,
  output logic              adv_en,
  output logic              busy,
  output logic              out_valid,
  output logic              out_native,
  output logic              out_read,
  output logic [ADDR_W-1:0] out_addr,
  output logic [SIZE_W-1:0] out_size,
  output logic [7:0]        out_data0,
  output logic              out_no_addr,
  output logic              out_no_stop,
  output logic              seq_done,
  output logic              seq_err
);

  seq_state_t        state;
  logic              r_native;
  logic              r_read;
  logic              r_mot;
  logic [ADDR_W-1:0] r_addr;
  logic [SIZE_W-1:0] r_size;
  logic [7:0]        r_data;
  logic              waiting;
  logic              ok_resp;

  assign accept  = in_valid && (state == ST_IDLE);
  assign busy    = (state != ST_IDLE);
  assign waiting = (state == ST_SEG_WAIT) || (state == ST_OFS_WAIT) ||
                   (state == ST_FWD_WAIT);
  assign ok_resp = fr_done && !fr_err;
  assign adv_en  = (state == ST_OFS_WAIT) && ok_resp;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_native <= 1'b0;
      r_read   <= 1'b0;
      r_mot    <= 1'b0;
      r_addr   <= '0;
      r_size   <= '0;
      r_data   <= '0;
    end else if (accept) begin
      r_native <= in_native;
      r_read   <= in_read;
      r_mot    <= in_mot;
      r_addr   <= in_addr;
      r_size   <= in_size;
      r_data   <= in_data0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      out_valid   <= 1'b0;
      out_native  <= 1'b0;
      out_read    <= 1'b0;
      out_addr    <= '0;
      out_size    <= '0;
      out_data0   <= '0;
      out_no_addr <= 1'b0;
      out_no_stop <= 1'b0;
      seq_done    <= 1'b0;
      seq_err     <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      seq_done  <= 1'b0;
      seq_err   <= 1'b0;
      if (waiting && fr_err) begin
        seq_err <= 1'b1;
        state   <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (accept) begin
              if (do_replay) begin
                state <= do_seg ? ST_SEG_SEND : ST_OFS_SEND;
              end else begin
                state <= ST_FWD_SEND;
              end
            end
          end
          ST_SEG_SEND: begin
            out_valid   <= 1'b1;
            out_native  <= 1'b0;
            out_read    <= 1'b0;
            out_addr    <= ADDR_W'(SEG_PTR_ADDR);
            out_size    <= SIZE_W'(1);
            out_data0   <= seg;
            out_no_addr <= 1'b1;
            out_no_stop <= 1'b1;
            state       <= ST_SEG_WAIT;
          end
          ST_SEG_WAIT: begin
            if (fr_done) begin
              state <= ST_OFS_SEND;
            end
          end
          ST_OFS_SEND: begin
            out_valid   <= 1'b1;
            out_native  <= 1'b0;
            out_read    <= 1'b0;
            out_addr    <= r_addr;
            out_size    <= SIZE_W'(1);
            out_data0   <= ofs[7:0];
            out_no_addr <= 1'b1;
            out_no_stop <= 1'b1;
            state       <= ST_OFS_WAIT;
          end
          ST_OFS_WAIT: begin
            if (fr_done) begin
              state <= ST_FWD_SEND;
            end
          end
          ST_FWD_SEND: begin
            out_valid   <= 1'b1;
            out_native  <= r_native;
            out_read    <= r_read;
            out_addr    <= r_addr;
            out_size    <= r_size;
            out_data0   <= r_data;
            out_no_addr <= !r_native;
            out_no_stop <= !r_native && r_mot;
            state       <= ST_FWD_WAIT;
          end
          ST_FWD_WAIT: begin
            if (fr_done) begin
              seq_done <= 1'b1;
              state    <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/edid_replay_seq.sv
module edid_replay_seq
  import edid_rs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int SIZE_W = 8,
  parameter int OFS_W  = 9,
  parameter int CHUNK  = 16,
  parameter int BLOCK  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_native,
  input  logic              in_read,
  input  logic              in_mot,
  input  logic              in_send_seg,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [SIZE_W-1:0] in_size,
  input  logic [7:0]        in_data0,
  output logic              in_busy,
  output logic              out_valid,
  output logic              out_native,
  output logic              out_read,
  output logic [ADDR_W-1:0] out_addr,
  output logic [SIZE_W-1:0] out_size,
  output logic [7:0]        out_data0,
  output logic              out_no_addr,
  output logic              out_no_stop,
  input  logic              fr_done,
  input  logic              fr_err,
  output logic              seq_done,
  output logic              seq_err
);

  logic             accept;
  logic             adv_en;
  logic             do_replay;
  logic             do_seg;
  logic [7:0]       seg;
  logic [OFS_W-1:0] ofs;

  edid_rs_tracker #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .CHUNK(CHUNK), .BLOCK(BLOCK)
  ) u_trk (
    .clk       (clk),
    .rst       (rst),
    .cap_en    (accept),
    .cap_native(in_native),
    .cap_read  (in_read),
    .cap_addr  (in_addr),
    .cap_data  (in_data0),
    .adv_en    (adv_en),
    .seg       (seg),
    .ofs       (ofs)
  );

  edid_rs_gate #(
    .SIZE_W(SIZE_W), .OFS_W(OFS_W), .BLOCK(BLOCK)
  ) u_gate (
    .req_native  (in_native),
    .req_read    (in_read),
    .req_mot     (in_mot),
    .req_send_seg(in_send_seg),
    .req_size    (in_size),
    .seg         (seg),
    .ofs         (ofs),
    .do_replay   (do_replay),
    .do_seg      (do_seg)
  );

  edid_rs_ctrl #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OFS_W(OFS_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_native  (in_native),
    .in_read    (in_read),
    .in_mot     (in_mot),
    .in_addr    (in_addr),
    .in_size    (in_size),
    .in_data0   (in_data0),
    .do_replay  (do_replay),
    .do_seg     (do_seg),
    .seg        (seg),
    .ofs        (ofs),
    .fr_done    (fr_done),
    .fr_err     (fr_err),
    .accept     (accept),
    .adv_en     (adv_en),
    .busy       (in_busy),
    .out_valid  (out_valid),
    .out_native (out_native),
    .out_read   (out_read),
    .out_addr   (out_addr),
    .out_size   (out_size),
    .out_data0  (out_data0),
    .out_no_addr(out_no_addr),
    .out_no_stop(out_no_stop),
    .seq_done   (seq_done),
    .seq_err    (seq_err)
  );

endmodule

// File: rtl/edid_rs_chk.sv
module edid_rs_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_busy,
  input logic out_valid,
  input logic out_native,
  input logic out_no_addr,
  input logic out_no_stop,
  input logic seq_done,
  input logic seq_err
);

  AST_PULSE_FRAME: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R9

  AST_FRAME_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_busy); // R9

  AST_I2C_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_native) |-> out_no_addr); // R6

  AST_NATIVE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_native) |-> (!out_no_addr && !out_no_stop)); // R6

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(seq_done && seq_err)); // R10

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
    seq_err |=> !out_valid); // R10

  AST_TAKE_REQ: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_busy) |=> in_busy); // R11

  AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
    (seq_done || seq_err) |-> !in_busy); // R11

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!out_valid && !in_busy && !seq_done && !seq_err)); // R12

endmodule

bind edid_replay_seq edid_rs_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_busy    (in_busy),
  .out_valid  (out_valid),
  .out_native (out_native),
  .out_no_addr(out_no_addr),
  .out_no_stop(out_no_stop),
  .seq_done   (seq_done),
  .seq_err    (seq_err)
);

// File: tb/edid_replay_seq_tb.sv
module edid_replay_seq_tb;

  localparam int ADDR_W = 20;
  localparam int SIZE_W = 8;
  localparam int NV     = 23;

  typedef struct packed {
    logic       nat;
    logic       rd;
    logic       mot;
    logic       ss;
    logic [7:0] addr;
    logic [7:0] size;
    logic [7:0] data;
    logic [1:0] n;
    logic [7:0] ea;
    logic [7:0] eb;
  } vec_t;

  // fields: native, read, mot, send_seg, addr, size, data0, frames, 1st data, 2nd data
  localparam vec_t VECS [NV] = '{
    {1'b0,1'b0,1'b1,1'b1,8'h30,8'h01,8'h01,2'd1,8'h00,8'h00}, // R1 seg=1
    {1'b0,1'b0,1'b0,1'b1,8'h50,8'h01,8'h10,2'd1,8'h00,8'h00}, // R1 ofs=0x10
    {1'b0,1'b1,1'b1,1'b1,8'h50,8'h10,8'h00,2'd3,8'h01,8'h10}, // R3 R4
    {1'b0,1'b1,1'b1,1'b1,8'h50,8'h10,8'h00,2'd3,8'h01,8'h20}, // R7
    {1'b0,1'b1,1'b1,1'b0,8'h50,8'h10,8'h00,2'd1,8'h00,8'h00}, // R2 hint off
    {1'b0,1'b1,1'b0,1'b1,8'h50,8'h10,8'h00,2'd1,8'h00,8'h00}, // R2 mot clear
    {1'b0,1'b1,1'b1,1'b1,8'h50,8'h00,8'h00,2'd1,8'h00,8'h00}, // R2 size 0
    {1'b1,1'b1,1'b1,1'b1,8'h50,8'h10,8'h00,2'd1,8'h00,8'h00}, // R2 native
    {1'b1,1'b0,1'b0,1'b1,8'h30,8'h01,8'h05,2'd1,8'h00,8'h00}, // R1 native not snooped
    {1'b0,1'b0,1'b0,1'b1,8'h50,8'h01,8'h70,2'd1,8'h00,8'h00},
    {1'b0,1'b1,1'b1,1'b1,8'h50,8'h10,8'h00,2'd3,8'h01,8'h70}, // R8 -> 0x80
    {1'b0,1'b1,1'b1,1'b1,8'h50,8'h10,8'h00,2'd1,8'h00,8'h00}, // R2 boundary
    {1'b0,1'b0,1'b0,1'b1,8'h50,8'h01,8'hF0,2'd1,8'h00,8'h00},
    {1'b0,1'b1,1'b1,1'b1,8'h50,8'h10,8'h00,2'd2,8'hF0,8'h00}, // R3 seg 0 skipped
    {1'b0,1'b0,1'b0,1'b1,8'h30,8'h01,8'h02,2'd1,8'h00,8'h00},
    {1'b0,1'b0,1'b0,1'b1,8'h50,8'h01,8'hF0,2'd1,8'h00,8'h00},
    {1'b0,1'b1,1'b1,1'b1,8'h50,8'h10,8'h00,2'd3,8'h02,8'hF0}, // R8 -> 0x100
    {1'b0,1'b1,1'b1,1'b1,8'h50,8'h10,8'h00,2'd1,8'h00,8'h00},
    {1'b0,1'b0,1'b0,1'b1,8'h50,8'h01,8'h20,2'd1,8'h00,8'h00},
    {1'b0,1'b1,1'b1,1'b1,8'h50,8'h10,8'h00,2'd2,8'h20,8'h00}, // R8 seg cleared
    {1'b0,1'b0,1'b0,1'b1,8'h51,8'h01,8'h33,2'd1,8'h00,8'h00}, // R1 other addr
    {1'b0,1'b1,1'b1,1'b1,8'h50,8'h10,8'h00,2'd2,8'h30,8'h00},
    {1'b0,1'b1,1'b1,1'b1,8'h52,8'h10,8'h00,2'd2,8'h40,8'h00}  // R4 read addr
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_native = 1'b0;
  logic              in_read = 1'b0;
  logic              in_mot = 1'b0;
  logic              in_send_seg = 1'b0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [SIZE_W-1:0] in_size = '0;
  logic [7:0]        in_data0 = '0;
  logic              in_busy;
  logic              out_valid;
  logic              out_native;
  logic              out_read;
  logic [ADDR_W-1:0] out_addr;
  logic [SIZE_W-1:0] out_size;
  logic [7:0]        out_data0;
  logic              out_no_addr;
  logic              out_no_stop;
  logic              fr_done = 1'b0;
  logic              fr_err = 1'b0;
  logic              seq_done;
  logic              seq_err;

  int total = 0;
  int bad   = 0;

  logic              f_nat [4];
  logic              f_rd  [4];
  logic [ADDR_W-1:0] f_addr[4];
  logic [SIZE_W-1:0] f_size[4];
  logic [7:0]        f_data[4];
  logic              f_na  [4];
  logic              f_ns  [4];
  int                fcnt;
  logic              got_done;
  logic              got_err;

  always #5 clk = ~clk;

  edid_replay_seq u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_native(in_native),
    .in_read(in_read), .in_mot(in_mot), .in_send_seg(in_send_seg),
    .in_addr(in_addr), .in_size(in_size), .in_data0(in_data0),
    .in_busy(in_busy), .out_valid(out_valid), .out_native(out_native),
    .out_read(out_read), .out_addr(out_addr), .out_size(out_size),
    .out_data0(out_data0), .out_no_addr(out_no_addr),
    .out_no_stop(out_no_stop), .fr_done(fr_done), .fr_err(fr_err),
    .seq_done(seq_done), .seq_err(seq_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_req(input vec_t v, input int err_at, input bit poke);
    int wait_n;
    fcnt = 0; got_done = 1'b0; got_err = 1'b0; wait_n = 0;
    @(negedge clk);
    in_native = v.nat; in_read = v.rd; in_mot = v.mot; in_send_seg = v.ss;
    in_addr = ADDR_W'(v.addr); in_size = v.size; in_data0 = v.data;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (poke) begin
      in_native = 1'b0; in_read = 1'b0; in_addr = ADDR_W'(8'h50);
      in_data0 = 8'h77; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
    end
    for (int t = 0; t < 300; t++) begin
      fr_done = 1'b0; fr_err = 1'b0;
      if (seq_done || seq_err) begin
        got_done = seq_done; got_err = seq_err;
        break;
      end
      if (out_valid) begin
        if (fcnt < 4) begin
          f_nat[fcnt] = out_native; f_rd[fcnt] = out_read;
          f_addr[fcnt] = out_addr; f_size[fcnt] = out_size;
          f_data[fcnt] = out_data0; f_na[fcnt] = out_no_addr;
          f_ns[fcnt] = out_no_stop;
        end
        fcnt++;
        wait_n = 2;
      end else if (wait_n > 0) begin
        wait_n--;
        if (wait_n == 0) begin
          if (fcnt - 1 == err_at) fr_err = 1'b1;
          else fr_done = 1'b1;
        end
      end
      @(negedge clk);
    end
  endtask

  task automatic check_inj(input int j, input logic [ADDR_W-1:0] a,
                           input logic [7:0] d, input string req);
    check(f_addr[j] == a, req, "replay addr", 32'(f_addr[j]), 32'(a));
    check(f_data[j] == d, req, "replay data", 32'(f_data[j]), 32'(d));
    check(f_size[j] == SIZE_W'(1) && !f_rd[j] && !f_nat[j], req, "replay write size",
          32'(f_size[j]), 32'd1);
    check(f_na[j] && f_ns[j], "R5", "replay flags", {30'd0, f_na[j], f_ns[j]}, 32'd3);
  endtask

  task automatic check_vec(input vec_t v, input int idx);
    int j;
    check(got_done && !got_err, "R11", $sformatf("vec %0d done", idx),
          {30'd0, got_done, got_err}, 32'd2);
    check(fcnt == int'(v.n), "R2", $sformatf("vec %0d frame count", idx),
          32'(fcnt), 32'(v.n));
    if (fcnt != int'(v.n) || fcnt == 0) return;
    if (v.n == 2'd3) begin
      check_inj(0, ADDR_W'(8'h30), v.ea, "R3");
      check_inj(1, ADDR_W'(v.addr), v.eb, "R4");
    end else if (v.n == 2'd2) begin
      check_inj(0, ADDR_W'(v.addr), v.ea, "R4");
    end
    j = fcnt - 1;
    check(f_nat[j] == v.nat && f_rd[j] == v.rd && f_addr[j] == ADDR_W'(v.addr) &&
          f_size[j] == v.size && f_data[j] == v.data, "R6",
          $sformatf("vec %0d forward fields", idx), 32'(f_addr[j]), 32'(v.addr));
    check(f_na[j] == !v.nat && f_ns[j] == (!v.nat && v.mot), "R6",
          $sformatf("vec %0d forward flags", idx), {30'd0, f_na[j], f_ns[j]},
          {30'd0, !v.nat, !v.nat && v.mot});
  endtask

  function automatic vec_t rd_vec(input logic [7:0] a);
    return {1'b0,1'b1,1'b1,1'b1,a,8'h10,8'h00,2'd0,8'h00,8'h00};
  endfunction

  function automatic vec_t wr_vec(input logic [7:0] a, input logic [7:0] d);
    return {1'b0,1'b0,1'b0,1'b1,a,8'h01,d,2'd1,8'h00,8'h00};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // R12 reset state at the ports
    check(!out_valid && !in_busy && !seq_done && !seq_err, "R12", "reset outputs",
          {28'd0, out_valid, in_busy, seq_done, seq_err}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run_req(VECS[i], -1, 1'b0);
      check_vec(VECS[i], i);
    end

    // R10: error on the offset frame aborts, offset (0x50) not advanced
    run_req(rd_vec(8'h50), 0, 1'b0);
    check(got_err && !got_done, "R10", "abort status", {30'd0, got_done, got_err}, 32'd1);
    check(fcnt == 1, "R10", "frames before abort", 32'(fcnt), 32'd1);
    v = rd_vec(8'h50); v.n = 2'd2; v.ea = 8'h50;
    run_req(v, -1, 1'b0);
    check_vec(v, 100);

    // R11: write to 0x50 while busy is ignored (offset now 0x60)
    v = rd_vec(8'h50); v.n = 2'd2; v.ea = 8'h60;
    run_req(v, -1, 1'b1);
    check_vec(v, 101);
    v = rd_vec(8'h50); v.n = 2'd2; v.ea = 8'h70;
    run_req(v, -1, 1'b0);
    check_vec(v, 102);

    // R10: error on the forwarded frame
    run_req(wr_vec(8'h50, 8'h10), 0, 1'b0);
    check(got_err && fcnt == 1, "R10", "forward error", 32'(fcnt), 32'd1);

    // R12: reset returns offset to 0, so a continued read is not replayed
    run_req(wr_vec(8'h50, 8'h10), -1, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check(!in_busy && !out_valid, "R12", "mid-run reset", {30'd0, in_busy, out_valid}, 32'd0);
    rst = 1'b0;
    v = rd_vec(8'h50); v.n = 2'd1;
    run_req(v, -1, 1'b0);
    check_vec(v, 103);

    // R9: no second frame before done - checked via a late response
    check(!out_valid, "R9", "quiet after run", {31'd0, out_valid}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule